// File: doc/BRIEF.md
# Ring-Shared Dual-Port Lookup RAM

This block gives every core in a closed ring of processing cores a private 512-word by 32-bit lookup memory with two ports. The first port is reserved for the owning core, which may read or write it at will. The second port is time-shared between two requesters. One is the owning core's streamer. The other is the core one position lower in the ring, which uses it for auxiliary loads and stores into its neighbour's memory.

The ring is closed, so the last core reaches the memory of core 0. Each core therefore has two memory connections: its own memory, and the memory of the core after it. Cores chained this way can pass data around the ring. A core can write into its successor's memory, and the successor reads the data back through its own private port.

On the shared port the neighbour always wins. A streamer that loses the port sees a stall in that same cycle and must hold its request. Reads on either port return data one clock after the address is presented. Read data on the shared port goes back only to whichever requester owned the port in that cycle.

Top module: `lutring_top`

## Requirements
- R1: Each memory holds DEPTH words of WIDTH bits (default 512 x 32, 9-bit address); a word written through the private port at any address, including 0 and DEPTH-1, is returned by a later private-port read of that address.
- R2: A private-port read (a_en=1, a_we=0) puts the word on a_rdata on the clock after the request, and the value is the one stored before any write in that same cycle; a_rdata keeps its value until the next private-port read.
- R3: Auxiliary requests of core i (x_* slice i) address the memory of core (i+1) mod NCORE, so core NCORE-1 reaches core 0; auxiliary read data returns on x_rdata slice i.
- R4: When core i's streamer and core i-1 (mod NCORE) both request in a cycle, the neighbour's operation is performed, s_stall[i] is 1 in that cycle, and the streamer's operation (read or write) is not performed; s_stall[i] is 0 whenever the neighbour does not request.
- R5: A granted streamer read raises s_rvalid one clock later, with the word on s_rdata; s_rdata is zero and s_rvalid low in every other cycle.
- R6: An auxiliary read raises x_rvalid one clock later, with the word on x_rdata; x_rdata is zero and x_rvalid low in every other cycle.
- R7: When the private port and the shared port write the same address in the same cycle, the private-port data is stored.
- R8: While and after synchronous active-high reset, a_rdata, s_rdata and x_rdata are zero and s_rvalid and x_rvalid are low until a read is made.
- R9: Writes on the shared port, from either requester, produce no s_rvalid or x_rvalid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | NCORE | Private-port request, one bit per core |
| a_we | input | NCORE | Private-port write enable |
| a_addr | input | NCORE*AW | Private-port word address, core i at bits [i*AW +: AW] |
| a_wdata | input | NCORE*WIDTH | Private-port write data |
| a_rdata | output | NCORE*WIDTH | Private-port read data |
| s_en | input | NCORE | Streamer request on the shared port of the core's own memory |
| s_we | input | NCORE | Streamer write enable |
| s_addr | input | NCORE*AW | Streamer word address |
| s_wdata | input | NCORE*WIDTH | Streamer write data |
| s_stall | output | NCORE | Streamer lost the shared port this cycle |
| s_rdata | output | NCORE*WIDTH | Streamer read data, zero outside its valid cycle |
| s_rvalid | output | NCORE | Streamer read data valid |
| x_en | input | NCORE | Auxiliary request from core i into memory of core i+1 |
| x_we | input | NCORE | Auxiliary write enable |
| x_addr | input | NCORE*AW | Auxiliary word address |
| x_wdata | input | NCORE*WIDTH | Auxiliary write data |
| x_rdata | output | NCORE*WIDTH | Auxiliary read data, zero outside its valid cycle |
| x_rvalid | output | NCORE | Auxiliary read data valid |

## Verification
The bench aims at the cycles where the neighbour and the streamer contend for the shared port. A design that let the streamer through, or merged both operations, would corrupt the word the neighbour stores, would miss the stall, or would return data to both requesters. It also drives same-address writes from both ports. A design with the wrong write order would keep the shared-port data instead of the private-port data. Ring wrap is aimed at directly, because an off-by-one in the ring wiring would send the last core's requests to a wrong memory. Random traffic over a few addresses also checks that reads return the old word when a write to the same address happens in the same cycle, and that a_rdata holds its value between reads.

// File: rtl/lutring_pkg.sv
package lutring_pkg;

  // owner of the shared port, remembered for the read-return cycle
  typedef enum logic [1:0] {
    PB_IDLE  = 2'd0,
    PB_NEIGH = 2'd1,
    PB_STRM  = 2'd2
  } pb_owner_e;

endpackage

// File: rtl/lutring_ram.sv
module lutring_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_q,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_q
);

  logic [WIDTH-1:0] mem [DEPTH];

  // shared-port write first, private-port write last so it wins a collision
  always_ff @(posedge clk) begin
    if (b_en && b_we) mem[b_addr] <= b_wdata;
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  // registered read, returns the word held before this cycle's writes
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en && !a_we) a_q <= mem[a_addr];
      if (b_en && !b_we) b_q <= mem[b_addr];
    end
  end

  // R2
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(a_en && !a_we) |-> $stable(a_q));

endmodule

// File: rtl/lutring_pbarb.sv
module lutring_pbarb
  import lutring_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nb_en,
  input  logic             nb_we,
  input  logic [AW-1:0]    nb_addr,
  input  logic [WIDTH-1:0] nb_wdata,
  input  logic             st_en,
  input  logic             st_we,
  input  logic [AW-1:0]    st_addr,
  input  logic [WIDTH-1:0] st_wdata,
  output logic             st_stall,
  output logic             b_en,
  output logic             b_we,
  output logic [AW-1:0]    b_addr,
  output logic [WIDTH-1:0] b_wdata,
  output pb_owner_e        owner_q
);

  logic nb_win;
  assign nb_win = nb_en;

  always_comb begin
    b_en    = nb_en | st_en;
    b_we    = nb_win ? nb_we    : st_we;
    b_addr  = nb_win ? nb_addr  : st_addr;
    b_wdata = nb_win ? nb_wdata : st_wdata;
  end

  assign st_stall = st_en & nb_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= PB_IDLE;
    end else if (nb_en) begin
      owner_q <= nb_we ? PB_IDLE : PB_NEIGH;
    end else if (st_en && !st_we) begin
      owner_q <= PB_STRM;
    end else begin
      owner_q <= PB_IDLE;
    end
  end

  // R4
  stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    st_stall |-> (nb_en && b_addr == nb_addr && b_we == nb_we));

  // R4
  no_strm_after_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (nb_en && st_en) |=> owner_q != PB_STRM);

endmodule

// File: rtl/lutring_slice.sv
module lutring_slice
  import lutring_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             st_en,
  input  logic             st_we,
  input  logic [AW-1:0]    st_addr,
  input  logic [WIDTH-1:0] st_wdata,
  output logic             st_stall,
  output logic [WIDTH-1:0] st_rdata,
  output logic             st_rvalid,
  input  logic             nb_en,
  input  logic             nb_we,
  input  logic [AW-1:0]    nb_addr,
  input  logic [WIDTH-1:0] nb_wdata,
  output logic [WIDTH-1:0] nb_rdata,
  output logic             nb_rvalid
);

  logic             b_en, b_we;
  logic [AW-1:0]    b_addr;
  logic [WIDTH-1:0] b_wdata, b_q;
  pb_owner_e        owner_q;

  lutring_pbarb #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .nb_en    (nb_en),
    .nb_we    (nb_we),
    .nb_addr  (nb_addr),
    .nb_wdata (nb_wdata),
    .st_en    (st_en),
    .st_we    (st_we),
    .st_addr  (st_addr),
    .st_wdata (st_wdata),
    .st_stall (st_stall),
    .b_en     (b_en),
    .b_we     (b_we),
    .b_addr   (b_addr),
    .b_wdata  (b_wdata),
    .owner_q  (owner_q)
  );

  lutring_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_q     (a_rdata),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_q     (b_q)
  );

  // steer shared-port read data only to the requester that owned the port
  assign st_rvalid = (owner_q == PB_STRM);
  assign nb_rvalid = (owner_q == PB_NEIGH);
  assign st_rdata  = st_rvalid ? b_q : '0;
  assign nb_rdata  = nb_rvalid ? b_q : '0;

  // R5
  strm_rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    st_rvalid |-> $past(st_en && !st_we && !nb_en));

  // R6
  nb_rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    nb_rvalid |-> $past(nb_en && !nb_we));

  // R9
  write_no_return_chk: assert property (@(posedge clk) disable iff (rst)
    (b_en && b_we) |=> !(st_rvalid || nb_rvalid));

endmodule

// File: rtl/lutring_top.sv
module lutring_top #(
  parameter int NCORE = 4,
  parameter int DEPTH = 512,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCORE-1:0]       a_en,
  input  logic [NCORE-1:0]       a_we,
  input  logic [NCORE*AW-1:0]    a_addr,
  input  logic [NCORE*WIDTH-1:0] a_wdata,
  output logic [NCORE*WIDTH-1:0] a_rdata,
  input  logic [NCORE-1:0]       s_en,
  input  logic [NCORE-1:0]       s_we,
  input  logic [NCORE*AW-1:0]    s_addr,
  input  logic [NCORE*WIDTH-1:0] s_wdata,
  output logic [NCORE-1:0]       s_stall,
  output logic [NCORE*WIDTH-1:0] s_rdata,
  output logic [NCORE-1:0]       s_rvalid,
  input  logic [NCORE-1:0]       x_en,
  input  logic [NCORE-1:0]       x_we,
  input  logic [NCORE*AW-1:0]    x_addr,
  input  logic [NCORE*WIDTH-1:0] x_wdata,
  output logic [NCORE*WIDTH-1:0] x_rdata,
  output logic [NCORE-1:0]       x_rvalid
);

  logic [WIDTH-1:0] nb_rdata_w  [NCORE];
  logic             nb_rvalid_w [NCORE];

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    localparam int PRV = (g == 0) ? NCORE - 1 : g - 1;
    localparam int NXT = (g == NCORE - 1) ? 0 : g + 1;

    // memory g: shared port is fed by core PRV's auxiliary requests
    lutring_slice #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .a_en      (a_en[g]),
      .a_we      (a_we[g]),
      .a_addr    (a_addr[g*AW +: AW]),
      .a_wdata   (a_wdata[g*WIDTH +: WIDTH]),
      .a_rdata   (a_rdata[g*WIDTH +: WIDTH]),
      .st_en     (s_en[g]),
      .st_we     (s_we[g]),
      .st_addr   (s_addr[g*AW +: AW]),
      .st_wdata  (s_wdata[g*WIDTH +: WIDTH]),
      .st_stall  (s_stall[g]),
      .st_rdata  (s_rdata[g*WIDTH +: WIDTH]),
      .st_rvalid (s_rvalid[g]),
      .nb_en     (x_en[PRV]),
      .nb_we     (x_we[PRV]),
      .nb_addr   (x_addr[PRV*AW +: AW]),
      .nb_wdata  (x_wdata[PRV*WIDTH +: WIDTH]),
      .nb_rdata  (nb_rdata_w[g]),
      .nb_rvalid (nb_rvalid_w[g])
    );

    // core g's auxiliary returns come from memory NXT
    assign x_rdata[g*WIDTH +: WIDTH] = nb_rdata_w[NXT];
    assign x_rvalid[g]               = nb_rvalid_w[NXT];

    // R3
    ring_stall_src_chk: assert property (@(posedge clk) disable iff (rst)
      s_stall[g] |-> (x_en[PRV] && s_en[g]));
  end

endmodule

// File: tb/lutring_top_tb.sv
module lutring_top_tb;

  localparam int  N      = 4;
  localparam int  D      = 512;
  localparam int  W      = 32;
  localparam int  AW     = $clog2(D);
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(PERIOD/2) clk = ~clk;

  logic [N-1:0]     a_en, a_we, s_en, s_we, x_en, x_we;
  logic [AW-1:0]    a_ad [N], s_ad [N], x_ad [N];
  logic [W-1:0]     a_wd [N], s_wd [N], x_wd [N];
  logic [N*AW-1:0]  a_addr, s_addr, x_addr;
  logic [N*W-1:0]   a_wdata, s_wdata, x_wdata;
  logic [N*W-1:0]   a_rdata, s_rdata, x_rdata;
  logic [N-1:0]     s_stall, s_rvalid, x_rvalid;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_addr[i*AW +: AW] = a_ad[i];
      s_addr[i*AW +: AW] = s_ad[i];
      x_addr[i*AW +: AW] = x_ad[i];
      a_wdata[i*W +: W]  = a_wd[i];
      s_wdata[i*W +: W]  = s_wd[i];
      x_wdata[i*W +: W]  = x_wd[i];
    end
  end

  lutring_top #(.NCORE(N), .DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_stall(s_stall), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
    .x_en(x_en), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
    .x_rdata(x_rdata), .x_rvalid(x_rvalid)
  );

  logic [W-1:0] mdl [N][D];
  logic [W-1:0] exp_a [N], exp_sd [N], exp_xd [N];
  logic         exp_sv [N], exp_xv [N];
  int nchk = 0, nfail = 0;
  bit done = 0;

  function automatic int prv(int i); return (i == 0) ? N - 1 : i - 1; endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  endtask

  task automatic idle();
    a_en = '0; a_we = '0; s_en = '0; s_we = '0; x_en = '0; x_we = '0;
    for (int i = 0; i < N; i++) begin
      a_ad[i] = '0; s_ad[i] = '0; x_ad[i] = '0;
      a_wd[i] = '0; s_wd[i] = '0; x_wd[i] = '0;
    end
  endtask

  function automatic string pick(string ovr, string dflt);
    return (ovr != "") ? ovr : dflt;
  endfunction

  // inputs are set just after an edge; check stall, model the edge, compare after it
  task automatic step(string ovr);
    #1;
    for (int j = 0; j < N; j++) begin
      int p = prv(j);
      logic g;
      chk(pick(ovr, "R4"), {31'd0, s_stall[j]}, {31'd0, s_en[j] & x_en[p]});
      g = s_en[j] & ~x_en[p];
      exp_xv[p] = x_en[p] & ~x_we[p];
      exp_xd[p] = exp_xv[p] ? mdl[j][x_ad[p]] : '0;
      exp_sv[j] = g & ~s_we[j];
      exp_sd[j] = exp_sv[j] ? mdl[j][s_ad[j]] : '0;
      if (a_en[j] && !a_we[j]) exp_a[j] = mdl[j][a_ad[j]];
      if (x_en[p] && x_we[p]) mdl[j][x_ad[p]] = x_wd[p];
      else if (g && s_we[j]) mdl[j][s_ad[j]] = s_wd[j];
      if (a_en[j] && a_we[j]) mdl[j][a_ad[j]] = a_wd[j];
    end
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin
      chk(pick(ovr, "R2"), a_rdata[i*W +: W], exp_a[i]);
      chk(pick(ovr, "R5"), {31'd0, s_rvalid[i]}, {31'd0, exp_sv[i]});
      chk(pick(ovr, "R5"), s_rdata[i*W +: W], exp_sd[i]);
      chk(pick(ovr, "R6"), {31'd0, x_rvalid[i]}, {31'd0, exp_xv[i]});
      chk(pick(ovr, "R6"), x_rdata[i*W +: W], exp_xd[i]);
    end
    idle();
  endtask

  initial begin
    #(PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5EED));
    idle();
    for (int i = 0; i < N; i++) begin
      exp_a[i] = '0; exp_sd[i] = '0; exp_xd[i] = '0; exp_sv[i] = 0; exp_xv[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R8: outputs during reset
    for (int i = 0; i < N; i++) begin
      chk("R8", a_rdata[i*W +: W], '0);
      chk("R8", {31'd0, s_rvalid[i] | x_rvalid[i]}, '0);
    end
    rst = 1'b0;
    step("R8");

    // R1: fill every word of every memory through the private port
    for (int ad = 0; ad < D; ad++) begin
      for (int i = 0; i < N; i++) begin
        a_en[i] = 1; a_we[i] = 1; a_ad[i] = AW'(ad); a_wd[i] = $urandom;
      end
      step("R1");
    end
    for (int i = 0; i < N; i++) begin a_en[i] = 1; a_ad[i] = AW'(D - 1); end
    step("R1");
    for (int i = 0; i < N; i++) begin a_en[i] = 1; a_ad[i] = '0; end
    step("R1");

    // R3: last core reads and writes memory 0 through its auxiliary path
    x_en[N-1] = 1; x_ad[N-1] = 9'd5;
    step("R3");
    x_en[N-1] = 1; x_we[N-1] = 1; x_ad[N-1] = 9'd6; x_wd[N-1] = 32'hA5A5_0006;
    step("R3");
    a_en[0] = 1; a_ad[0] = 9'd6;
    step("R3");

    // R4: neighbour write beats streamer write to memory 1
    x_en[0] = 1; x_we[0] = 1; x_ad[0] = 9'd7; x_wd[0] = 32'h1111_0007;
    s_en[1] = 1; s_we[1] = 1; s_ad[1] = 9'd7; s_wd[1] = 32'h2222_0007;
    step("R4");
    a_en[1] = 1; a_ad[1] = 9'd7;
    step("R4");
    // R4: neighbour read beats streamer read; no streamer return
    x_en[0] = 1; x_ad[0] = 9'd8; s_en[1] = 1; s_ad[1] = 9'd9;
    step("R4");

    // R7: private-port write wins a same-address collision
    a_en[1] = 1; a_we[1] = 1; a_ad[1] = 9'd9; a_wd[1] = 32'h3333_0009;
    x_en[0] = 1; x_we[0] = 1; x_ad[0] = 9'd9; x_wd[0] = 32'h4444_0009;
    step("R7");
    a_en[1] = 1; a_ad[1] = 9'd9;
    step("R7");
    a_en[2] = 1; a_we[2] = 1; a_ad[2] = 9'd10; a_wd[2] = 32'h5555_000A;
    s_en[2] = 1; s_we[2] = 1; s_ad[2] = 9'd10; s_wd[2] = 32'h6666_000A;
    step("R7");
    s_en[2] = 1; s_ad[2] = 9'd10;
    step("R7");

    // R9: writes return nothing
    s_en[3] = 1; s_we[3] = 1; s_ad[3] = 9'd11; s_wd[3] = 32'h7777_000B;
    x_en[3] = 1; x_we[3] = 1; x_ad[3] = 9'd12; x_wd[3] = 32'h8888_000C;
    step("R9");

    // random traffic over a small address window to force collisions
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        a_en[i] = ($urandom % 2) == 0; a_we[i] = ($urandom % 3) == 0;
        s_en[i] = ($urandom % 2) == 0; s_we[i] = ($urandom % 3) == 0;
        x_en[i] = ($urandom % 3) == 0; x_we[i] = ($urandom % 2) == 0;
        a_ad[i] = AW'($urandom % 8); s_ad[i] = AW'($urandom % 8); x_ad[i] = AW'($urandom % 8);
        a_wd[i] = $urandom; s_wd[i] = $urandom; x_wd[i] = $urandom;
      end
      step("");
    end
    summary();
  end

endmodule